// File: doc/BRIEF.md
# Capture and Auto-Reload Timer

A 16-bit timer built from two byte-wide count halves and a paired 16-bit capture/reload register, all loaded one byte per write through a small register port. It runs in one of two modes. In auto-reload mode it steps once per clock while running. On an overflow it restarts from the value held in the capture/reload register. The count direction can be handed to an external pin. In capture mode it counts up freely. A falling edge on the same pin snapshots the count into the capture/reload register, and the count can optionally be cleared at the same time.

Two sticky flags report overflow/underflow events and captures, and software clears each one with a pulse. An optional clock output toggles on every overflow, so it gives a square wave at half the overflow rate.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the count and the capture/reload register are 0x0000, both flags are 0, clock-out is 0 and the control byte is 0 (auto-reload mode, stopped, counting up).
- R2: Write address map: 0 count low byte, 1 count high byte, 2 capture/reload low byte, 3 capture/reload high byte, 4 control. Control bits: bit0 run, bit1 capture mode, bit2 clear-on-capture, bit3 clock-out enable, bit4 direction-pin enable. In auto-reload mode with up counting, each running cycle adds one. The step after 0xFFFF loads the reload value and sets the overflow flag.
- R3: In auto-reload mode with bit4 = 1 and the synchronized pin at 0, the count steps down. When the count equals the reload value, the next step loads 0xFFFF and sets the overflow flag.
- R4: With bit4 = 0 the count goes up whatever the pin level is. With bit4 = 1 and the pin at 1, it also goes up.
- R5: In capture mode the count wraps from 0xFFFF to 0x0000 and sets the overflow flag. Counting leaves the capture/reload register unchanged.
- R6: The pin passes through a two-flop synchronizer. In capture mode a synchronized falling edge copies the full 16-bit count into the capture/reload register and sets the capture flag. Rising edges, and any edge in auto-reload mode, change neither the register nor the flag.
- R7: With clear-on-capture set, the count becomes 0x0000 in the same cycle as the copy. With it clear, the count is kept.
- R8: With clock-out enabled, the clock output toggles on every overflow. With it disabled, the output is 0.
- R9: With run = 0 and no count write, the count holds.
- R10: A write to a count byte in a cycle where the timer would step wins: the written byte is stored, the other byte keeps its value, and no step happens.
- R11: Each flag stays set until its clear input is pulsed. If a set and a clear happen in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| ext_i | input | 1 | Capture trigger / direction pin, asynchronous |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| cap_clr_i | input | 1 | Clears the capture flag |
| count_o | output | 16 | Current count |
| cap_o | output | 16 | Capture/reload register |
| ovf_flag_o | output | 1 | Sticky overflow/underflow flag |
| cap_flag_o | output | 1 | Sticky capture flag |
| clk_out_o | output | 1 | Divided clock output |

## Verification
The properties assume that `ext_i` sits high through reset, so that releasing reset does not look like a falling edge. They also assume that the direction pin does not change while a running reload sits at its limit value. Their antecedents exclude cycles with any register write, so each property only covers hardware-driven updates. The stimulus follows these assumptions: it changes `ext_i` only while the timer is stopped, and it waits several cycles after each change before running or checking.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 5;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;

  typedef struct packed {
    logic dir_pin_en;  // bit4
    logic clk_out_en;  // bit3
    logic clr_on_cap;  // bit2
    logic cap_mode;    // bit1
    logic run;         // bit0
  } ctrl_t;
endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= RST_VAL;
        else if (i == 0) sync_q[i] <= pin_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/crt_counter.sv
module crt_counter
  import crt_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic              down_i,
  input  logic              fall_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic              ovf_evt_o,
  output logic              cap_evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q, cap_d, step_val;
  logic             at_lim, wr_clo, wr_chi, wr_rlo, wr_rhi, cnt_wr, cap_evt;

  always_comb begin
    wr_clo  = wr_en_i && (wr_addr_i == A_CNT_LO);
    wr_chi  = wr_en_i && (wr_addr_i == A_CNT_HI);
    wr_rlo  = wr_en_i && (wr_addr_i == A_CAP_LO);
    wr_rhi  = wr_en_i && (wr_addr_i == A_CAP_HI);
    cnt_wr  = wr_clo | wr_chi;
    cap_evt = ctrl_i.cap_mode & fall_i;

    if (ctrl_i.cap_mode) begin
      at_lim   = (cnt_q == CNT_MAX);
      step_val = cnt_q + CNT_W'(1);
    end else if (down_i) begin
      at_lim   = (cnt_q == cap_q);
      step_val = at_lim ? CNT_MAX : cnt_q - CNT_W'(1);
    end else begin
      at_lim   = (cnt_q == CNT_MAX);
      step_val = at_lim ? cap_q : cnt_q + CNT_W'(1);
    end

    cnt_d = cnt_q;
    if (ctrl_i.run)                   cnt_d = step_val;
    if (cap_evt && ctrl_i.clr_on_cap) cnt_d = '0;
    // software byte writes take priority over hardware updates
    if (wr_clo) cnt_d = {cnt_q[CNT_W-1:BYTE_W], wr_data_i};
    if (wr_chi) cnt_d = {wr_data_i, cnt_q[BYTE_W-1:0]};

    cap_d = cap_q;
    if (cap_evt) cap_d = cnt_q;
    if (wr_rlo)  cap_d = {cap_q[CNT_W-1:BYTE_W], wr_data_i};
    if (wr_rhi)  cap_d = {wr_data_i, cap_q[BYTE_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cap_q <= cap_d;
    end
  end

  assign count_o   = cnt_q;
  assign cap_o     = cap_q;
  assign ovf_evt_o = ctrl_i.run & at_lim & ~cnt_wr;
  assign cap_evt_o = cap_evt;
endmodule

// File: rtl/crt_flags.sv
module crt_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_evt_i,
  input  logic cap_evt_i,
  input  logic ovf_clr_i,
  input  logic cap_clr_i,
  input  logic clk_en_i,
  output logic ovf_flag_o,
  output logic cap_flag_o,
  output logic clk_out_o
);
  logic ovf_q, cap_q, clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      cap_q <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      ovf_q <= ovf_evt_i | (ovf_q & ~ovf_clr_i);
      cap_q <= cap_evt_i | (cap_q & ~cap_clr_i);
      if (!clk_en_i)      clk_q <= 1'b0;
      else if (ovf_evt_i) clk_q <= ~clk_q;
    end
  end

  assign ovf_flag_o = ovf_q;
  assign cap_flag_o = cap_q;
  assign clk_out_o  = clk_q;
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import crt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ext_i,
  input  logic              ovf_clr_i,
  input  logic              cap_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  cap_o,
  output logic              ovf_flag_o,
  output logic              cap_flag_o,
  output logic              clk_out_o
);
  ctrl_t ctrl_q;
  logic  ext_lvl, ext_fall, cnt_down, ovf_evt, cap_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == A_CTRL) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
  end

  crt_edge_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (ext_i),
    .level_o (ext_lvl),
    .fall_o  (ext_fall)
  );

  assign cnt_down = ctrl_q.dir_pin_en & ~ext_lvl;

  crt_counter #(.BYTE_W(BYTE_W)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl_q),
    .down_i    (cnt_down),
    .fall_i    (ext_fall),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .count_o   (count_o),
    .cap_o     (cap_o),
    .ovf_evt_o (ovf_evt),
    .cap_evt_o (cap_evt)
  );

  crt_flags i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ovf_evt_i  (ovf_evt),
    .cap_evt_i  (cap_evt),
    .ovf_clr_i  (ovf_clr_i),
    .cap_clr_i  (cap_clr_i),
    .clk_en_i   (ctrl_q.clk_out_en),
    .ovf_flag_o (ovf_flag_o),
    .cap_flag_o (cap_flag_o),
    .clk_out_o  (clk_out_o)
  );
endmodule

// File: rtl/crt_checker.sv
module crt_checker
  import crt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             ovf_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic [CNT_W-1:0] cap_o,
  input logic             ovf_flag_o,
  input logic             cap_flag_o,
  input logic             clk_out_o,
  input ctrl_t            ctrl_q,
  input logic             cnt_down,
  input logic             ext_fall
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  AST_UP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.run && !ctrl_q.cap_mode && !cnt_down && count_o == MAXV && !wr_en_i)
    |=> (count_o == $past(cap_o) && ovf_flag_o)); // R2

  AST_DOWN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.run && !ctrl_q.cap_mode && cnt_down && count_o == cap_o && !wr_en_i)
    |=> (count_o == MAXV && ovf_flag_o)); // R3

  AST_CAP_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.cap_mode && ext_fall && !wr_en_i)
    |=> (cap_o == $past(count_o) && cap_flag_o)); // R6

  AST_RELOAD_KEEPS_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.cap_mode && !wr_en_i) |=> $stable(cap_o)); // R6

  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.run && !ctrl_q.clr_on_cap && !wr_en_i) |=> $stable(count_o)); // R9

  AST_CLKOUT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.clk_out_en |=> !clk_out_o); // R8

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o); // R11
endmodule

bind cap_reload_timer crt_checker #(.CNT_W(CNT_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .ovf_clr_i  (ovf_clr_i),
  .count_o    (count_o),
  .cap_o      (cap_o),
  .ovf_flag_o (ovf_flag_o),
  .cap_flag_o (cap_flag_o),
  .clk_out_o  (clk_out_o),
  .ctrl_q     (ctrl_q),
  .cnt_down   (cnt_down),
  .ext_fall   (ext_fall)
);

// File: tb/test_cap_reload_timer.sv
`timescale 1ns/1ps
module test_cap_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        ext = 1'b1;
  logic        ovf_clr = 1'b0;
  logic        cap_clr = 1'b0;
  logic [15:0] count, cap;
  logic        ovf_flag, cap_flag, clk_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cap_reload_timer i_cap_reload_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ext_i(ext), .ovf_clr_i(ovf_clr), .cap_clr_i(cap_clr),
    .count_o(count), .cap_o(cap), .ovf_flag_o(ovf_flag), .cap_flag_o(cap_flag),
    .clk_out_o(clk_out)
  );

  typedef struct packed {
    logic [7:0]  ctrl;
    logic        pin;
    logic [15:0] cnt;
    logic [15:0] rld;
    logic [7:0]  steps;
    logic [15:0] exp_cnt;
    logic        exp_ovf;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 1'b1, 16'h0010, 16'h1234, 8'd5, 16'h0015, 1'b0}, // R2 plain up
    '{8'h00, 1'b1, 16'hFFFE, 16'h1234, 8'd3, 16'h1235, 1'b1}, // R2 reload on overflow
    '{8'h10, 1'b0, 16'h1236, 16'h1234, 8'd4, 16'hFFFE, 1'b1}, // R3 down past reload
    '{8'h10, 1'b1, 16'h00FF, 16'h1234, 8'd2, 16'h0101, 1'b0}, // R4 pin high -> up
    '{8'h00, 1'b0, 16'h0100, 16'h1234, 8'd3, 16'h0103, 1'b0}, // R4 pin ignored
    '{8'h02, 1'b1, 16'hFFFF, 16'h5555, 8'd2, 16'h0001, 1'b1}  // R5 capture-mode wrap
  };

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // called at a negedge, returns at the next negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr16(input logic [2:0] a_lo, input logic [15:0] v);
    wr(a_lo, v[7:0]);
    wr(a_lo + 3'd1, v[15:8]);
  endtask

  task automatic clr_flags();
    ovf_clr = 1'b1; cap_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0; cap_clr = 1'b0;
  endtask

  // exactly n counting edges (n >= 1)
  task automatic run_steps(input logic [7:0] ctrl, input int n);
    wr(3'd4, ctrl | 8'h01);
    repeat (n - 1) @(negedge clk);
    wr(3'd4, ctrl & 8'hFE);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "count", count, 16'h0000);
    chk("R1", "cap", cap, 16'h0000);
    chk("R1", "ovf_flag", {15'd0, ovf_flag}, 16'd0);
    chk("R1", "cap_flag", {15'd0, cap_flag}, 16'd0);
    chk("R1", "clk_out", {15'd0, clk_out}, 16'd0);

    for (int v = 0; v < NV; v++) begin
      ext = VECS[v].pin;
      repeat (4) @(negedge clk);
      wr(3'd4, VECS[v].ctrl);
      wr16(3'd0, VECS[v].cnt);
      wr16(3'd2, VECS[v].rld);
      clr_flags();
      run_steps(VECS[v].ctrl, int'(VECS[v].steps));
      chk("R2-R5 vec", "count", count, VECS[v].exp_cnt);
      chk("R2-R5 vec", "ovf_flag", {15'd0, ovf_flag}, {15'd0, VECS[v].exp_ovf});
      chk("R5", "cap untouched", cap, VECS[v].rld);
      chk("R8", "clk_out off", {15'd0, clk_out}, 16'd0);
    end

    // R6 / R7: capture without clear
    ext = 1'b1; repeat (4) @(negedge clk);
    wr(3'd4, 8'h02);
    wr16(3'd0, 16'hABCD);
    clr_flags();
    ext = 1'b0; repeat (5) @(negedge clk);
    chk("R6", "captured", cap, 16'hABCD);
    chk("R6", "cap_flag", {15'd0, cap_flag}, 16'd1);
    chk("R7", "count kept", count, 16'hABCD);
    repeat (3) @(negedge clk);
    chk("R11", "cap_flag sticky", {15'd0, cap_flag}, 16'd1);
    clr_flags();
    chk("R11", "cap_flag cleared", {15'd0, cap_flag}, 16'd0);
    ext = 1'b1; repeat (5) @(negedge clk);
    chk("R6", "rising edge no flag", {15'd0, cap_flag}, 16'd0);

    // R7: capture with clear
    wr(3'd4, 8'h06);
    wr16(3'd0, 16'h2222);
    ext = 1'b0; repeat (5) @(negedge clk);
    chk("R7", "captured", cap, 16'h2222);
    chk("R7", "count cleared", count, 16'h0000);

    // R6: edges ignored in reload mode
    ext = 1'b1; repeat (4) @(negedge clk);
    wr(3'd4, 8'h00);
    clr_flags();
    wr16(3'd0, 16'h3333);
    ext = 1'b0; repeat (5) @(negedge clk);
    chk("R6", "reload mode cap kept", cap, 16'h2222);
    chk("R6", "reload mode no flag", {15'd0, cap_flag}, 16'd0);

    // R8: clock out, overflow every 4 steps
    ext = 1'b1; repeat (4) @(negedge clk);
    wr16(3'd0, 16'hFFFC);
    wr16(3'd2, 16'hFFFC);
    wr(3'd4, 8'h08);
    run_steps(8'h08, 4);
    chk("R8", "clk_out toggled", {15'd0, clk_out}, 16'd1);
    run_steps(8'h08, 4);
    chk("R8", "clk_out toggled back", {15'd0, clk_out}, 16'd0);
    chk("R8", "count", count, 16'hFFFC);

    // R10: write beats step, then R9 hold
    wr(3'd4, 8'h00);
    wr16(3'd0, 16'h0500);
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h80);
    chk("R10", "write priority", count, 16'h0580);
    wr(3'd4, 8'h00);
    repeat (5) @(negedge clk);
    chk("R9", "held while stopped", count, 16'h0581);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule